// File: doc/BRIEF.md
# EEPROM Access Controller with CPU Stall

This block sits on a small processor's register bus, in front of an on-chip EEPROM array. Software loads an address register and a data register, then sets a bit in a control register to start an access. A read returns the addressed byte into the data register on the following cycle. A write captures the address and the byte, stays busy for a fixed number of pulses from a slow timing clock, and only then commits the byte to the array. While the write is pending, software polls the busy bit until it reads zero.

Each accepted access holds the processor through a stall output for a fixed number of processor cycles. A read stalls for four cycles and a write start stalls for two. While a write is pending, the address register is frozen and new read or write requests are dropped. The timing clock reaches the block as a one-cycle enable pulse in the processor clock domain.

Register select on `busAddr`: 0 is the address register, 1 is the data register, 2 is the control register, and 3 reads as zero. In the control register, bit 0 is the read strobe and bit 1 is the write-start/busy bit.

Top module: `eeprom_access_ctrl`

## Requirements
- R1: After reset the control register reads 0 (busy clear), `cpuStall` is low, `memWe` is low and the write timer is zero.
- R2: Writing the control register with bit 1 set while idle starts a write. The control register then reads back with bit 1 set, and the current address and data register values are captured for the commit.
- R3: A started write commits after exactly WRITE_TICKS cycles in which `timeTick` is high. Cycles without `timeTick` do not advance it. In the cycle of the last tick, `memWe` is high with the captured address on `memAddr` and the captured byte on `memWdata`. From the next cycle, bit 1 of the control register reads 0.
- R4: An accepted write start drives `cpuStall` high for exactly WR_STALL (default 2) cycles, beginning in the cycle after the control register write.
- R5: Writing the control register with bit 0 set while idle reads the array at the address register. The byte is in the data register from the next cycle. Bit 0 always reads back as 0.
- R6: An accepted read drives `cpuStall` high for exactly RD_STALL (default 4) cycles, beginning in the cycle after the request.
- R7: While a write is pending, writes to the address register are ignored. Read requests are also ignored: they cause no stall and leave the data register unchanged.
- R8: A write request made while a write is pending is ignored. It causes no stall and does not restart the timer, so the commit still comes on the original tick count.
- R9: A control register write with both bits set while idle is treated as a write. The read is dropped, and the stall lasts WR_STALL cycles.
- R10: The data register can be written while a write is pending, and it reads back the new value. The pending commit still stores the byte captured at the write start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access valid |
| busWe | input | 1 | Access is a register write |
| busAddr | input | 2 | Register select |
| busWdata | input | DATA_W | Register write data |
| busRdata | output | DATA_W | Read-back of the selected register (combinational) |
| timeTick | input | 1 | One-cycle enable from the write-timing clock |
| cpuStall | output | 1 | Processor hold request |
| memAddr | output | ADDR_W | Array address |
| memWdata | output | DATA_W | Array write byte |
| memWe | output | 1 | Array write strobe, one cycle at commit |
| memRdata | input | DATA_W | Array read byte for `memAddr` (combinational) |

## Verification
The bench targets the commit boundary. It spreads timing ticks across random idle gaps and checks that busy is still set and the array is untouched after one tick fewer than the count. A design that also counted idle cycles, or that was off by one, would commit early or late. While a write is pending, the bench sends address writes, reads and second write starts. A design that did not lock these out would move the commit address, overwrite the data register, add stalls or restart the timer. Stall lengths are counted cycle by cycle for both access types and for the combined request. The bench also updates the data register during a pending write, which shows whether the commit uses the captured byte or the live register.

// File: rtl/eeprom_access_pkg.sv
package eeprom_access_pkg;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTRL_RD_BIT = 0;
  localparam int CTRL_WR_BIT = 1;

  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic startWrite;
    logic startRead;
    logic commit;
    logic writeBusy;
  } eeCtlStrobes_t;

endpackage

// File: rtl/eeprom_access_ctl.sv
module eeprom_access_ctl
  import eeprom_access_pkg::*;
#(
  parameter int WRITE_TICKS = 26368,
  parameter int WR_STALL    = 2,
  parameter int RD_STALL    = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busSel,
  input  logic          busWe,
  input  logic [1:0]    busAddr,
  input  logic          wrBit,
  input  logic          rdBit,
  input  logic          timeTick,
  output eeCtlStrobes_t strobes,
  output logic          cpuStall
);

  localparam int TMR_W     = $clog2(WRITE_TICKS + 1);
  localparam int STALL_MAX = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;
  localparam int STALL_W   = $clog2(STALL_MAX + 1);

  logic               busy;
  logic [TMR_W-1:0]   timer;
  logic [STALL_W-1:0] stallCnt;
  logic               regWr;
  logic               ctrlWr;
  logic               lastTick;

  always_comb begin
    regWr    = busSel && busWe;
    ctrlWr   = regWr && (busAddr == SEL_CTRL);
    lastTick = (timer == TMR_W'(WRITE_TICKS - 1));

    strobes.writeBusy  = busy;
    strobes.loadAddr   = regWr && (busAddr == SEL_ADDR) && !busy;
    strobes.loadData   = regWr && (busAddr == SEL_DATA);
    strobes.startWrite = ctrlWr && wrBit && !busy;
    strobes.startRead  = ctrlWr && rdBit && !wrBit && !busy;
    strobes.commit     = busy && timeTick && lastTick;
  end

  // Write-busy flag and tick counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      timer <= '0;
    end else if (strobes.startWrite) begin
      busy  <= 1'b1;
      timer <= '0;
    end else if (busy && timeTick) begin
      if (lastTick) begin
        busy  <= 1'b0;
        timer <= '0;
      end else begin
        timer <= timer + TMR_W'(1);
      end
    end
  end

  // Processor stall counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0;
    end else if (strobes.startWrite) begin
      stallCnt <= STALL_W'(WR_STALL);
    end else if (strobes.startRead) begin
      stallCnt <= STALL_W'(RD_STALL);
    end else if (stallCnt != '0) begin
      stallCnt <= stallCnt - STALL_W'(1);
    end
  end

  assign cpuStall = (stallCnt != '0);

  // R3: busy persists until the final tick
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strobes.commit |=> busy);

  // R3: commit ends the write
  a_r3_commit_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !busy);

  // R3: no tick, no progress
  a_r3_idle_timer: assert property (@(posedge clk) disable iff (!rstN)
    busy && !timeTick |=> $stable(timer));

  // R4: write start stalls the processor
  a_r4_wr_stall: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startWrite |=> cpuStall);

  // R6: read stalls the processor
  a_r6_rd_stall: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startRead |=> cpuStall);

  // R7: stall appears only after an accepted access
  a_r7_no_spurious_stall: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.startWrite && !strobes.startRead && !cpuStall |=> !cpuStall);

  // R8: pending write never rewinds its timer
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strobes.commit |=>
      (timer == $past(timer)) || (timer == $past(timer) + TMR_W'(1)));

endmodule

// File: rtl/eeprom_access_dp.sv
module eeprom_access_dp
  import eeprom_access_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeCtlStrobes_t     strobes,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strobes.loadAddr) begin
      addrReg <= ADDR_W'(busWdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobes.startRead) begin
      dataReg <= memRdata;
    end else if (strobes.loadData) begin
      dataReg <= busWdata;
    end
  end

  // Snapshot taken at write start, used at commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr <= '0;
      wrData <= '0;
    end else if (strobes.startWrite) begin
      wrAddr <= addrReg;
      wrData <= dataReg;
    end
  end

  always_comb begin
    memAddr  = strobes.writeBusy ? wrAddr : addrReg;
    memWdata = wrData;
    memWe    = strobes.commit;
    unique case (busAddr)
      SEL_ADDR: busRdata = DATA_W'(addrReg);
      SEL_DATA: busRdata = dataReg;
      SEL_CTRL: busRdata = DATA_W'({strobes.writeBusy, 1'b0});
      default:  busRdata = '0;
    endcase
  end

  // R5: read data lands in the data register next cycle
  a_r5_read_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startRead |=> dataReg == $past(memRdata));

  // R7: address register frozen during a pending write
  a_r7_addr_locked: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeBusy |=> $stable(addrReg));

  // R10: commit snapshot stays fixed while busy
  a_r10_snapshot_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeBusy |=> $stable(wrData) && $stable(wrAddr));

endmodule

// File: rtl/eeprom_access_ctrl.sv
module eeprom_access_ctrl
  import eeprom_access_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int WRITE_TICKS = 26368,
  parameter int WR_STALL    = 2,
  parameter int RD_STALL    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              timeTick,
  output logic              cpuStall,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata
);

  eeCtlStrobes_t strobes;

  eeprom_access_ctl #(
    .WRITE_TICKS(WRITE_TICKS),
    .WR_STALL   (WR_STALL),
    .RD_STALL   (RD_STALL)
  ) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .wrBit   (busWdata[CTRL_WR_BIT]),
    .rdBit   (busWdata[CTRL_RD_BIT]),
    .timeTick(timeTick),
    .strobes (strobes),
    .cpuStall(cpuStall)
  );

  eeprom_access_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .memRdata(memRdata),
    .busRdata(busRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memWe   (memWe)
  );

endmodule

// File: tb/eeprom_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeprom_access_ctrl_tb_top;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int TICKS  = 20;
  localparam int WR_ST  = 2;
  localparam int RD_ST  = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWe = 1'b0;
  logic [1:0]        busAddr = 2'd0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              timeTick = 1'b0;
  logic              cpuStall;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              memWe;
  logic [DATA_W-1:0] memRdata;

  logic [DATA_W-1:0] mem    [DEPTH];
  logic [DATA_W-1:0] refMem [DEPTH];

  int nTests = 0;
  int nFail  = 0;

  always #5 clk = ~clk;

  eeprom_access_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_TICKS(TICKS),
    .WR_STALL(WR_ST), .RD_STALL(RD_ST)
  ) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .timeTick(timeTick), .cpuStall(cpuStall), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata)
  );

  assign memRdata = mem[memAddr];
  always @(posedge clk) if (memWe) mem[memAddr] <= memWdata;

  function automatic logic [DATA_W-1:0] seedByte(int i);
    return DATA_W'(i * 7 + 3);
  endfunction

  function automatic logic [DATA_W-1:0] expCtrl(logic busyExp);
    return DATA_W'({busyExp, 1'b0});
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic readReg(logic [1:0] a, output logic [DATA_W-1:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  // Count stall cycles; called right after the access edge
  task automatic measureStall(output int n);
    n = 0;
    while (cpuStall && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic doTicks(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
      @(negedge clk);
      timeTick = 1'b1;
      @(negedge clk);
      timeTick = 1'b0;
    end
  endtask

  task automatic fullWrite(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, string tag);
    int st;
    logic [DATA_W-1:0] v;
    busWrite(2'd0, a);
    busWrite(2'd1, d);
    busWrite(2'd2, 8'h02);
    measureStall(st);
    check({tag, " R4 write stall length"}, st, WR_ST);
    readReg(2'd2, v);
    check({tag, " R2 busy set"}, v, expCtrl(1'b1));
    doTicks(TICKS - 1, 1'b1);
    readReg(2'd2, v);
    check({tag, " R3 busy before last tick"}, v, expCtrl(1'b1));
    check({tag, " R3 array untouched early"}, mem[a], refMem[a]);
    doTicks(1, 1'b0);
    refMem[a] = d;
    readReg(2'd2, v);
    check({tag, " R3 busy cleared"}, v, expCtrl(1'b0));
    check({tag, " R3 array committed"}, mem[a], d);
  endtask

  task automatic fullRead(logic [ADDR_W-1:0] a, string tag);
    int st;
    logic [DATA_W-1:0] v;
    busWrite(2'd0, a);
    busWrite(2'd2, 8'h01);
    measureStall(st);
    check({tag, " R6 read stall length"}, st, RD_ST);
    readReg(2'd1, v);
    check({tag, " R5 read data"}, v, refMem[a]);
    readReg(2'd2, v);
    check({tag, " R5 read bit self clears"}, v, 0);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    int st;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]    = seedByte(i);
      refMem[i] = seedByte(i);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(2'd2, v);
    check("R1 ctrl after reset", v, 0);
    check("R1 stall after reset", cpuStall, 0);
    check("R1 memWe after reset", memWe, 0);
    readReg(2'd0, v);
    check("R1 addr after reset", v, 0);

    // Directed write then read back
    fullWrite(8'h10, 8'hA5, "dir");
    fullRead(8'h10, "dir");
    fullRead(8'hFF, "dir-top");

    // R7, R8, R10: lockout during a pending write
    busWrite(2'd0, 8'h22);
    busWrite(2'd1, 8'h5C);
    busWrite(2'd2, 8'h02);
    measureStall(st);
    busWrite(2'd0, 8'h33);
    readReg(2'd0, v);
    check("R7 addr write ignored while busy", v, 8'h22);
    busWrite(2'd2, 8'h01);
    check("R7 read while busy no stall", cpuStall, 0);
    readReg(2'd1, v);
    check("R7 data unchanged by blocked read", v, 8'h5C);
    busWrite(2'd1, 8'h99);
    readReg(2'd1, v);
    check("R10 data writable while busy", v, 8'h99);
    doTicks(3, 1'b1);
    busWrite(2'd2, 8'h02);
    check("R8 second write no stall", cpuStall, 0);
    doTicks(TICKS - 4, 1'b1);
    readReg(2'd2, v);
    check("R8 still busy at original count minus one", v, expCtrl(1'b1));
    doTicks(1, 1'b0);
    readReg(2'd2, v);
    check("R8 done at original count", v, expCtrl(1'b0));
    check("R10 commit used captured byte", mem[8'h22], 8'h5C);
    check("R7 blocked address untouched", mem[8'h33], refMem[8'h33]);
    refMem[8'h22] = 8'h5C;

    // R9: both bits set means write
    busWrite(2'd0, 8'h44);
    busWrite(2'd1, 8'h7E);
    busWrite(2'd2, 8'h03);
    measureStall(st);
    check("R9 combined request stall", st, WR_ST);
    readReg(2'd2, v);
    check("R9 combined request busy", v, expCtrl(1'b1));
    readReg(2'd1, v);
    check("R9 read dropped, data kept", v, 8'h7E);
    doTicks(TICKS, 1'b1);
    check("R9 combined request committed", mem[8'h44], 8'h7E);
    refMem[8'h44] = 8'h7E;

    // Random mix
    for (int k = 0; k < 25; k++) begin
      logic [ADDR_W-1:0] ra;
      logic [DATA_W-1:0] rd;
      ra = ADDR_W'($urandom);
      rd = DATA_W'($urandom);
      if ($urandom_range(0, 1) == 0) fullWrite(ra, rd, "rnd");
      else fullRead(ra, "rnd");
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule